// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Tag Controller

This block holds the tag state of a large direct-mapped, write-back backup cache placed between a processor and a shared system bus. Each processor request is looked up against a per-line record of a block tag, a valid flag and a dirty flag. The block then reports a hit, or it runs the miss sequence: an optional victim write-back request, a read-miss request, and a fill of one 64-byte line.

The processor side is a simple request/ready/done handshake. On the bus side, a 4-bit command is held until the bus acknowledges it. Fill data then comes in as 144-bit beats, each made of 128 data bits and 16 check bits. The block steers each beat to the line's slot in the external data RAM. It does not hold line data, build check bits or arbitrate for the bus.

Top module: `cc_ctrl`

## Requirements
- R1: After reset no line is valid, so the first access to any line index misses and requests a fill.
- R2: An access whose index selects a valid line with a matching tag is a hit, whatever its byte offset within the 64-byte block.
- R3: An access to a valid line whose stored tag differs from the request's tag (address bits 35:12) is a miss.
- R4: A miss drives `bus_cmd` = 4'h2 (read miss) with `bus_addr` equal to the requested address with bits 5:0 cleared.
- R5: A fill accepts exactly four beats. Each beat with `fill_valid` high drives `line_we` with `line_wdata` = `fill_data`, `line_index` = request bits 11:6, and `line_beat` counting 0,1,2,3 in arrival order. Cycles with `fill_valid` low write nothing.
- R6: `cpu_done` for a miss comes only after the fourth beat. `cpu_ready` stays low from acceptance until `cpu_done`.
- R7: A write hit marks the line dirty. A later miss on that line's index first drives `bus_cmd` = 4'h5 (victim write-back) with `bus_addr` = {stored tag, index, 6'b0}, and only after that drives the read miss.
- R8: A miss whose victim line is valid but clean issues no write-back command.
- R9: Completing a read fill leaves the line clean.
- R10: A write miss leaves the line dirty once its fill completes.
- R11: A hit issues no bus command.
- R12: A nonzero `bus_cmd` and its `bus_addr` hold steady until the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 36 | Physical byte address |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Valid with `cpu_done`: the lookup hit |
| bus_cmd | output | 4 | 0 idle, 2 read miss, 5 victim write-back |
| bus_addr | output | 36 | Block address of the command |
| bus_ack | input | 1 | Bus has taken the current command |
| fill_valid | input | 1 | A fill beat is present |
| fill_data | input | 144 | Fill beat: data and check bits |
| line_we | output | 1 | Write one beat into the data RAM |
| line_index | output | 6 | Data RAM line index |
| line_beat | output | 2 | Beat slot within the line |
| line_wdata | output | 144 | Beat written to the data RAM |

## Verification
The hardest case to reach is a dirty victim whose dirty flag must later read as clear again. This needs a write hit, then a conflicting miss on the same index that forces the write-back, then another conflicting miss that must not write back. The bench runs that exact chain with three tags on one index. It also holds back each bus acknowledge for a cycle and inserts a gap in the fill beats, which exercises command holding and beat counting under stalls.

// File: rtl/cc_pkg.sv
package cc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_VWB,
      ST_RMISS,
      ST_FILL,
      ST_DONE
   } cc_state_e;

   localparam logic [3:0] CMD_NONE      = 4'h0;
   localparam logic [3:0] CMD_READ_MISS = 4'h2;
   localparam logic [3:0] CMD_VICTIM_WB = 4'h5;
endpackage

// File: rtl/cc_tag_store.sv
module cc_tag_store #(
   parameter int IDX_W = 6,
   parameter int TAG_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_dirty,
   input  logic             mark_dirty,
   input  logic [IDX_W-1:0] mark_idx
);
   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
         end else if (mark_dirty) begin
            dirty_q[mark_idx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[wr_idx] <= wr_tag;
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/cc_fill_seq.sv
module cc_fill_seq #(
   parameter int BEATS  = 4,
   parameter int BCNT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   output logic [BCNT_W-1:0] beat,
   output logic              last
);
   generate
      if (BEATS > 1) begin : g_count
         logic [BCNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt_q <= '0;
            else if (clear) cnt_q <= '0;
            else if (step)  cnt_q <= cnt_q + 1'b1;
         end
         assign beat = cnt_q;
         assign last = (cnt_q == BCNT_W'(BEATS - 1));
      end else begin : g_single
         assign beat = '0;
         assign last = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl #(
   parameter int ADDR_W     = 36,
   parameter int LINE_BYTES = 64,
   parameter int DATA_W     = 128,
   parameter int CHECK_W    = 16,
   parameter int IDX_W      = 6,
   localparam int BEAT_W    = DATA_W + CHECK_W,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
   localparam int BEATS     = (LINE_BYTES * 8) / DATA_W,
   localparam int BCNT_W    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic              cpu_hit,
   output logic [3:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_ack,
   input  logic              fill_valid,
   input  logic [BEAT_W-1:0] fill_data,
   output logic              line_we,
   output logic [IDX_W-1:0]  line_index,
   output logic [BCNT_W-1:0] line_beat,
   output logic [BEAT_W-1:0] line_wdata
);
   import cc_pkg::*;

   initial begin
      if (BEATS * DATA_W != LINE_BYTES * 8) $error("line size is not a whole number of beats");
      if (TAG_W < 1) $error("address too narrow for index and offset");
      if ((1 << OFF_W) != LINE_BYTES) $error("line size must be a power of two");
   end

   cc_state_e         state_q, state_d;
   logic [ADDR_W-1:0] rq_addr_q;
   logic              rq_we_q;
   logic              hit_q;

   logic [IDX_W-1:0]  rq_idx;
   logic [TAG_W-1:0]  rq_tag;
   logic              ts_valid, ts_dirty;
   logic [TAG_W-1:0]  ts_tag;
   logic              lookup_hit;
   logic              beat_take, beat_last;
   logic              fill_end;

   assign rq_idx = rq_addr_q[OFF_W +: IDX_W];
   assign rq_tag = rq_addr_q[ADDR_W-1 -: TAG_W];

   cc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (rq_idx),
      .rd_valid   (ts_valid),
      .rd_dirty   (ts_dirty),
      .rd_tag     (ts_tag),
      .wr_en      (fill_end),
      .wr_idx     (rq_idx),
      .wr_tag     (rq_tag),
      .wr_dirty   (rq_we_q),
      .mark_dirty ((state_q == ST_LOOK) && lookup_hit && rq_we_q),
      .mark_idx   (rq_idx)
   );

   cc_fill_seq #(.BEATS(BEATS), .BCNT_W(BCNT_W)) u_fill (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_q == ST_RMISS),
      .step  (beat_take),
      .beat  (line_beat),
      .last  (beat_last)
   );

   assign lookup_hit = ts_valid && (ts_tag == rq_tag);
   assign beat_take  = (state_q == ST_FILL) && fill_valid;
   assign fill_end   = beat_take && beat_last;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (cpu_req) state_d = ST_LOOK;
         ST_LOOK: begin
            if (lookup_hit)              state_d = ST_DONE;
            else if (ts_valid && ts_dirty) state_d = ST_VWB;
            else                         state_d = ST_RMISS;
         end
         ST_VWB:   if (bus_ack) state_d = ST_RMISS;
         ST_RMISS: if (bus_ack) state_d = ST_FILL;
         ST_FILL:  if (fill_end) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rq_addr_q <= '0;
         rq_we_q   <= 1'b0;
         hit_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && cpu_req) begin
            rq_addr_q <= cpu_addr;
            rq_we_q   <= cpu_we;
         end
         if (state_q == ST_LOOK) hit_q <= lookup_hit;
      end
   end

   always_comb begin
      bus_cmd  = CMD_NONE;
      bus_addr = '0;
      if (state_q == ST_VWB) begin
         bus_cmd  = CMD_VICTIM_WB;
         bus_addr = {ts_tag, rq_idx, {OFF_W{1'b0}}};
      end else if (state_q == ST_RMISS) begin
         bus_cmd  = CMD_READ_MISS;
         bus_addr = {rq_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end
   end

   assign cpu_ready  = (state_q == ST_IDLE);
   assign cpu_done   = (state_q == ST_DONE);
   assign cpu_hit    = cpu_done && hit_q;
   assign line_we    = beat_take;
   assign line_index = rq_idx;
   assign line_wdata = fill_data;
endmodule

// File: rtl/cc_ctrl_chk.sv
module cc_ctrl_chk #(
   parameter int ADDR_W = 36,
   parameter int OFF_W  = 6,
   parameter int BEATS  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ready,
   input logic              cpu_done,
   input logic              cpu_hit,
   input logic [3:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_ack,
   input logic              line_we
);
   logic [7:0] beats_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        beats_seen <= '0;
      else if (cpu_done) beats_seen <= '0;
      else if (line_we)  beats_seen <= beats_seen + 8'd1;
   end

   // R12
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd != 4'h0 && !bus_ack) |=> ($stable(bus_cmd) && $stable(bus_addr)));

   // R4
   miss_addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd != 4'h0) |-> (bus_addr[OFF_W-1:0] == '0));

   // R6
   miss_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && !cpu_hit) |-> (beats_seen == 8'(BEATS)));

   // R11
   hit_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && cpu_hit) |-> (beats_seen == 8'd0));

   // R6
   busy_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_we |-> !cpu_ready);

   // R4
   cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == 4'h0 || bus_cmd == 4'h2 || bus_cmd == 4'h5));
endmodule

bind cc_ctrl cc_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BEATS(BEATS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_ready (cpu_ready),
   .cpu_done  (cpu_done),
   .cpu_hit   (cpu_hit),
   .bus_cmd   (bus_cmd),
   .bus_addr  (bus_addr),
   .bus_ack   (bus_ack),
   .line_we   (line_we)
);

// File: tb/test_cc_ctrl.sv
module test_cc_ctrl;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         cpu_req, cpu_we;
   logic [35:0]  cpu_addr;
   logic         cpu_ready, cpu_done, cpu_hit;
   logic [3:0]   bus_cmd;
   logic [35:0]  bus_addr;
   logic         bus_ack;
   logic         fill_valid;
   logic [143:0] fill_data;
   logic         line_we;
   logic [5:0]   line_index;
   logic [1:0]   line_beat;
   logic [143:0] line_wdata;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #4 clk = ~clk;

   cc_ctrl i_cc_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
      .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_ack(bus_ack),
      .fill_valid(fill_valid), .fill_data(fill_data),
      .line_we(line_we), .line_index(line_index), .line_beat(line_beat), .line_wdata(line_wdata)
   );

   function automatic logic [35:0] mk(input logic [23:0] tag, input logic [5:0] idx, input logic [5:0] off);
      return {tag, idx, off};
   endfunction

   function automatic logic [143:0] mem_beat(input logic [35:0] blk, input int b);
      return {16'hA5A5 ^ 16'(b), 92'h0, blk};
   endfunction

   task automatic check(input bit ok, input string rq, input logic [143:0] act, input logic [143:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // One processor access with a bus model answering the miss sequence.
   task automatic access(input logic [35:0] a, input logic we, input bit exp_hit,
                         input bit exp_wb, input logic [35:0] wb_addr, input string rq);
      bit saw_wb = 0, saw_rm = 0, order_ok = 1, done = 0;
      int beats = 0;
      logic [35:0] blk = {a[35:6], 6'b0};
      @(negedge clk);
      check(cpu_ready == 1'b1, {rq, " ready before access (R6)"}, 144'(cpu_ready), 144'(1));
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
      @(negedge clk);
      cpu_req = 1'b0;
      for (int cyc = 0; cyc < 60 && !done; cyc++) begin
         if (cpu_done) begin
            done = 1;
         end else if (bus_cmd == 4'h5) begin
            saw_wb = 1;
            if (saw_rm) order_ok = 0;
            check(bus_addr == wb_addr, {rq, " victim address (R7)"}, 144'(bus_addr), 144'(wb_addr));
            @(negedge clk);
            check(bus_cmd == 4'h5 && bus_addr == wb_addr, {rq, " held command (R12)"},
                  144'({bus_cmd, bus_addr}), 144'({4'h5, wb_addr}));
            bus_ack = 1'b1;
            @(negedge clk);
            bus_ack = 1'b0;
         end else if (bus_cmd == 4'h2) begin
            saw_rm = 1;
            check(bus_addr == blk, {rq, " read-miss address (R4)"}, 144'(bus_addr), 144'(blk));
            @(negedge clk);
            check(bus_cmd == 4'h2 && bus_addr == blk, {rq, " held command (R12)"},
                  144'({bus_cmd, bus_addr}), 144'({4'h2, blk}));
            bus_ack = 1'b1;
            @(negedge clk);
            bus_ack = 1'b0;
            for (int b = 0; b < 4; b++) begin
               if (b == 2) begin
                  fill_valid = 1'b0;
                  #1;
                  check(line_we == 1'b0, {rq, " idle beat gap (R5)"}, 144'(line_we), 144'(0));
                  check(cpu_done == 1'b0, {rq, " done before last beat (R6)"}, 144'(cpu_done), 144'(0));
                  @(negedge clk);
               end
               fill_valid = 1'b1;
               fill_data  = mem_beat(blk, b);
               #1;
               check(line_we && line_index == a[11:6] && line_beat == 2'(b) && line_wdata == mem_beat(blk, b),
                     {rq, " fill beat (R5)"},
                     {line_we, line_index, line_beat, line_wdata[134:0]},
                     {1'b1, a[11:6], 2'(b), mem_beat(blk, b)[134:0]});
               beats++;
               @(negedge clk);
            end
            fill_valid = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
      check(done, {rq, " completion seen (R6)"}, 144'(done), 144'(1));
      check(cpu_hit == exp_hit, {rq, " hit flag"}, 144'(cpu_hit), 144'(exp_hit));
      check(saw_wb == exp_wb, {rq, " write-back issued"}, 144'(saw_wb), 144'(exp_wb));
      check(saw_rm == !exp_hit, {rq, " read miss issued (R11)"}, 144'(saw_rm), 144'(!exp_hit));
      check(order_ok, {rq, " write-back before read miss (R7)"}, 144'(order_ok), 144'(1));
      check(beats == (exp_hit ? 0 : 4), {rq, " beat count (R5)"}, 144'(beats), 144'(exp_hit ? 0 : 4));
   endtask

   task automatic test_reset();
      @(negedge clk);
      check(cpu_ready == 1'b1 && cpu_done == 1'b0, "R1 reset handshake", 144'({cpu_ready, cpu_done}), 144'(2'b10));
      check(bus_cmd == 4'h0 && line_we == 1'b0, "R1 reset bus idle", 144'({bus_cmd, line_we}), 144'(0));
   endtask

   task automatic test_first_and_hit();
      access(mk(24'h1, 6'd3, 6'd8), 1'b0, 1'b0, 1'b0, 36'h0, "R1 first access");
      access(mk(24'h1, 6'd3, 6'd8), 1'b0, 1'b1, 1'b0, 36'h0, "R2 repeat read");
      access(mk(24'h1, 6'd3, 6'd60), 1'b0, 1'b1, 1'b0, 36'h0, "R2 other offset");
   endtask

   task automatic test_dirty_chain();
      access(mk(24'h1, 6'd3, 6'd0), 1'b1, 1'b1, 1'b0, 36'h0, "R7 write hit");
      access(mk(24'h2, 6'd3, 6'd4), 1'b0, 1'b0, 1'b1, mk(24'h1, 6'd3, 6'd0), "R3 conflict dirty");
      access(mk(24'h3, 6'd3, 6'd4), 1'b0, 1'b0, 1'b0, 36'h0, "R9 refilled clean");
   endtask

   task automatic test_clean_victim();
      access(mk(24'h1, 6'd9, 6'd0), 1'b0, 1'b0, 1'b0, 36'h0, "R1 new index");
      access(mk(24'h2, 6'd9, 6'd0), 1'b0, 1'b0, 1'b0, 36'h0, "R8 clean victim");
   endtask

   task automatic test_write_miss();
      access(mk(24'h4, 6'd5, 6'd16), 1'b1, 1'b0, 1'b0, 36'h0, "R10 write miss");
      access(mk(24'h4, 6'd5, 6'd0), 1'b0, 1'b1, 1'b0, 36'h0, "R2 after write fill");
      access(mk(24'hABCDE, 6'd5, 6'd0), 1'b0, 1'b0, 1'b1, mk(24'h4, 6'd5, 6'd0), "R10 dirty after fill");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0;
      bus_ack = 1'b0; fill_valid = 1'b0; fill_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_first_and_hit();
      test_dirty_chain();
      test_clean_victim();
      test_write_miss();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule